// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces a pulse-width modulated waveform for dimming a display backlight. A host programs it through a byte-wide register port: an 8-bit prescaler, a 16-bit step limit that sets the period, a 16-bit duty threshold and a two-bit control field. Two chained counters run on the block clock, which serves as the reference clock. The first counter divides the clock by the prescaler. The second counter walks through the steps of one period. The output is active while the step count is below the duty threshold.

The register port is a plain control interface. It has no back-pressure: a write strobe is taken on every clock edge where it is high, and read data is a combinational function of the address. Period and duty settings written during a run are copied into working registers only at a period boundary, so a period is never cut short or made from mixed settings. Enable and polarity take effect at once.

Top module: `bl_pwm_top`

## Requirements
- R1: While reset is held and right after it, every register reads 0x00 and `pwm_out` is low.
- R2: The register window starts at parameter `BASE` (default 0xA0). Offset 0 holds the prescaler. Offsets 1 and 2 hold the step limit, low byte first. Offsets 3 and 4 hold the duty threshold, low byte first. Offset 5 holds control. A write is taken at the clock edge where `wr_en` is high, and a read of that address then returns the written byte.
- R3: In the control byte, bit 0 inverts the output and bit 1 enables it. Bits 7:2 always read as zero. A write to an address outside the six-byte window changes no register, and a read of such an address returns 0x00.
- R4: With prescaler D and step limit S, one period lasts 1 + D*S clock cycles. Step 0 lasts one cycle, and each of steps 1 to S lasts D cycles.
- R5: The active level is asserted while the step count is below the duty threshold B. A period therefore holds 0 active cycles when B = 0 and 1 + D*(B-1) active cycles when 1 <= B <= S. The active cycles come first.
- R6: A duty threshold above the step limit keeps the output at its active level for the whole period.
- R7: With the invert bit set, `pwm_out` is the complement of the active level. Without it, active is high.
- R8: While disabled, `pwm_out` rests at its inactive level (the invert bit value) and both counters are held at zero. Setting enable starts a fresh period in the first cycle after the write edge.
- R9: A prescaler of zero behaves as a prescaler of one.
- R10: Prescaler, step limit and duty values written while enabled take effect from the next period boundary. The period in progress completes with the old values.
- R11: A step limit of zero gives a one-cycle period. The output then stays constant: active if the duty threshold is non-zero, inactive if it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that drives both counters |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register address for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte for `reg_addr` |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions assume that reset is applied before the first use. They also assume that only the working copies of the settings bound the counters, so they check counter ranges against those copies and not against the host-visible registers. The stimulus sets the period and duty registers while the block is disabled, except in the boundary test. That test lands its writes in the first cycles of a long period, well before the boundary edge, so the expected waveform of the old period and of the new ones can be stated exactly. Each expected waveform is built from the cycle counts in the requirements, one output bit per clock cycle.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int PRE_W   = 8;
  localparam int STEP_W  = 16;
  localparam int NREG    = 6;
  localparam int OFS_DIV    = 0;
  localparam int OFS_SCL_LO = 1;
  localparam int OFS_SCL_HI = 2;
  localparam int OFS_DTY_LO = 3;
  localparam int OFS_DTY_HI = 4;
  localparam int OFS_CTRL   = 5;
  localparam int CTRL_INV_BIT = 0;
  localparam int CTRL_EN_BIT  = 1;
  localparam logic [7:0] CTRL_MASK = 8'h03;

  typedef struct packed {
    logic [PRE_W-1:0]  div;
    logic [STEP_W-1:0] scale;
    logic [STEP_W-1:0] duty;
  } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter logic [7:0] BASE = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output pwm_cfg_t   cfg,
  output logic       ctrl_en,
  output logic       ctrl_inv
);
  localparam int BANK_W = NREG * 8;

  logic [BANK_W-1:0] bank;
  logic [7:0]        ofs;
  logic              hit;

  // Unsigned wrap makes addresses below BASE fall outside the window too.
  assign ofs = reg_addr - BASE;
  assign hit = (ofs < 8'(NREG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= '0;
    end else if (wr_en && hit) begin
      for (int i = 0; i < NREG; i++) begin
        if (ofs == 8'(i)) begin
          if (i == OFS_CTRL) bank[i*8 +: 8] <= wr_data & CTRL_MASK;
          else               bank[i*8 +: 8] <= wr_data;
        end
      end
    end
  end

  assign rd_data = hit ? bank[{ofs[2:0], 3'b000} +: 8] : 8'h00;

  assign cfg.div   = bank[OFS_DIV*8 +: PRE_W];
  assign cfg.scale = {bank[OFS_SCL_HI*8 +: 8], bank[OFS_SCL_LO*8 +: 8]};
  assign cfg.duty  = {bank[OFS_DTY_HI*8 +: 8], bank[OFS_DTY_LO*8 +: 8]};
  assign ctrl_en   = bank[OFS_CTRL*8 + CTRL_EN_BIT];
  assign ctrl_inv  = bank[OFS_CTRL*8 + CTRL_INV_BIT];
endmodule

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  pwm_cfg_t cfg_in,
  output pwm_cfg_t cfg_act
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cfg_act <= '0;
    else if (load) cfg_act <= cfg_in;
  end
endmodule

// File: rtl/bl_pwm_count.sv
module bl_pwm_count
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PRE_W-1:0]  div,
  input  logic [STEP_W-1:0] scale,
  output logic [PRE_W-1:0]  pre_cnt,
  output logic [STEP_W-1:0] step_cnt,
  output logic              period_end
);
  logic [PRE_W-1:0] div_eff;
  logic             last_pre;

  assign div_eff    = (div == '0) ? PRE_W'(1) : div;
  assign last_pre   = (pre_cnt == div_eff - PRE_W'(1));
  assign period_end = en && (step_cnt == scale) && ((step_cnt == '0) || last_pre);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || period_end) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else if (step_cnt == '0) begin
      pre_cnt  <= '0;
      step_cnt <= STEP_W'(1);
    end else if (last_pre) begin
      pre_cnt  <= '0;
      step_cnt <= step_cnt + STEP_W'(1);
    end else begin
      pre_cnt  <= pre_cnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/bl_pwm_out.sv
module bl_pwm_out
  import bl_pwm_pkg::*;
(
  input  logic              en,
  input  logic              inv,
  input  logic [STEP_W-1:0] step_cnt,
  input  logic [STEP_W-1:0] duty,
  output logic              pwm_out
);
  logic active;

  assign active  = (step_cnt < duty);
  assign pwm_out = en ? (active ^ inv) : inv;
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter logic [7:0] BASE = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       pwm_out
);
  pwm_cfg_t          cfg_host;
  pwm_cfg_t          cfg_act;
  logic              ctrl_en;
  logic              ctrl_inv;
  logic [PRE_W-1:0]  pre_cnt;
  logic [STEP_W-1:0] step_cnt;
  logic              period_end;
  logic              cfg_load;
  logic [PRE_W-1:0]  act_div;
  logic [STEP_W-1:0] act_scale;
  logic [STEP_W-1:0] act_duty;

  assign cfg_load  = !ctrl_en || period_end;
  assign act_div   = cfg_act.div;
  assign act_scale = cfg_act.scale;
  assign act_duty  = cfg_act.duty;

  bl_pwm_regs #(.BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .cfg(cfg_host),
    .ctrl_en(ctrl_en), .ctrl_inv(ctrl_inv)
  );

  bl_pwm_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .cfg_in(cfg_host), .cfg_act(cfg_act)
  );

  bl_pwm_count u_count (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .div(act_div), .scale(act_scale),
    .pre_cnt(pre_cnt), .step_cnt(step_cnt), .period_end(period_end)
  );

  bl_pwm_out u_out (
    .en(ctrl_en), .inv(ctrl_inv), .step_cnt(step_cnt), .duty(act_duty), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_out,
  input logic              en,
  input logic              inv,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic [STEP_W-1:0] step_cnt,
  input logic [PRE_W-1:0]  act_div,
  input logic [STEP_W-1:0] act_scale,
  input logic [STEP_W-1:0] act_duty,
  input logic              period_end
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pwm_out == inv); // R8
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (step_cnt == '0 && pre_cnt == '0)); // R8
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (step_cnt == '0 && pre_cnt == '0)); // R8
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> step_cnt <= act_scale); // R4
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> pre_cnt < ((act_div == '0) ? PRE_W'(1) : act_div)); // R9
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_end) |=> ($stable(act_div) && $stable(act_scale) && $stable(act_duty))); // R10
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_duty > act_scale) |-> pwm_out != inv); // R6
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_duty == '0) |-> pwm_out == inv); // R5
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .en(ctrl_en), .inv(ctrl_inv),
  .pre_cnt(pre_cnt), .step_cnt(step_cnt), .act_div(act_div), .act_scale(act_scale),
  .act_duty(act_duty), .period_end(period_end)
);

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'hA0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        pwm_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_pwm_top #(.BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // Monitor: one expected output bit per cycle, compared away from the edge.
  always @(negedge clk) begin
    logic  e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (pwm_out !== e) begin
        n_bad++;
        $display("FAIL %s: pwm_out actual=%0b expected=%0b", t, pwm_out, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    n_vec++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s: rd_data[%02h] actual=%02h expected=%02h", tag, a, rd_data, e);
    end
  endtask

  task automatic push_level(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  // Expected waveform from the cycle counts of R4/R5/R6/R9.
  task automatic push_wave(input int div, input int scale, input int duty,
                           input bit inv, input int nper, input string tag);
    int d, p, h;
    d = (div == 0) ? 1 : div;
    p = 1 + d * scale;
    if (duty == 0)         h = 0;
    else if (duty > scale) h = p;
    else                   h = 1 + d * (duty - 1);
    for (int k = 0; k < nper; k++)
      for (int i = 0; i < p; i++) begin
        exp_q.push_back((i < h) ^ inv);
        tag_q.push_back(tag);
      end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic cfg(input int div, input int scale, input int duty);
    wr(BASE + 8'd0, 8'(div));
    wr(BASE + 8'd1, 8'(scale));
    wr(BASE + 8'd2, 8'(scale >> 8));
    wr(BASE + 8'd3, 8'(duty));
    wr(BASE + 8'd4, 8'(duty >> 8));
  endtask

  task automatic run(input int div, input int scale, input int duty,
                     input bit inv, input int nper, input string tag);
    wr(BASE + 8'd5, {7'b0, inv});
    cfg(div, scale, duty);
    wr(BASE + 8'd5, {6'b0, 1'b1, inv});
    push_wave(div, scale, duty, inv, nper, tag);
    drain();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run state actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (pwm_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: pwm_out in reset actual=%0b expected=0", pwm_out);
    end
    for (int i = 0; i < 6; i++) chk_rd(BASE + 8'(i), 8'h00, "R1 reset register");
    @(negedge clk) rst_n = 1'b1;
    push_level(1'b0, 3, "R1 idle after reset");
    drain();

    // R2: map and readback
    cfg(8'h5A, 16'h1234, 16'hBEEF);
    chk_rd(BASE + 8'd0, 8'h5A, "R2 prescaler");
    chk_rd(BASE + 8'd1, 8'h34, "R2 step limit low");
    chk_rd(BASE + 8'd2, 8'h12, "R2 step limit high");
    chk_rd(BASE + 8'd3, 8'hEF, "R2 duty low");
    chk_rd(BASE + 8'd4, 8'hBE, "R2 duty high");

    // R3: reserved control bits, out-of-window writes
    wr(BASE + 8'd5, 8'hFC);
    chk_rd(BASE + 8'd5, 8'h00, "R3 control reserved bits");
    wr(BASE + 8'd5, 8'hFD);
    chk_rd(BASE + 8'd5, 8'h01, "R3 control invert only");
    push_level(1'b1, 4, "R8 R7 disabled inverted rests high");
    drain();
    wr(BASE + 8'd6, 8'h77);
    wr(BASE - 8'd1, 8'h55);
    chk_rd(BASE + 8'd6, 8'h00, "R3 read outside window");
    chk_rd(BASE + 8'd0, 8'h5A, "R3 prescaler untouched");
    chk_rd(BASE + 8'd5, 8'h01, "R3 control untouched");
    chk_rd(BASE + 8'd4, 8'hBE, "R3 duty high untouched");

    // R4/R5: basic waveforms
    run(3, 4, 2, 1'b0, 3, "R4 R5 div3 scale4 duty2");
    run(2, 4, 0, 1'b0, 2, "R5 zero duty");
    run(2, 4, 9, 1'b0, 2, "R6 duty above scale");
    run(2, 3, 1, 1'b1, 3, "R7 inverted div2 scale3 duty1");
    run(0, 5, 3, 1'b0, 3, "R9 prescaler zero");
    run(5, 0, 1, 1'b0, 6, "R11 scale zero duty set");
    run(3, 0, 0, 1'b0, 4, "R11 scale zero duty clear");
    run(1, 7, 2, 1'b0, 0, "R8 enable start");

    // R10: changes mid-run wait for boundary
    wr(BASE + 8'd5, 8'h00);
    cfg(1, 7, 2);
    wr(BASE + 8'd5, 8'h02);
    push_wave(1, 7, 2, 1'b0, 1, "R10 old period completes");
    push_wave(2, 7, 5, 1'b0, 2, "R10 new settings at boundary");
    wr(BASE + 8'd3, 8'd5);
    wr(BASE + 8'd0, 8'd2);
    drain();

    // R8: disable mid-run
    wr(BASE + 8'd5, 8'h00);
    push_level(1'b0, 5, "R8 disabled rests low");
    drain();
    wr(BASE + 8'd5, 8'h02);
    push_wave(2, 7, 5, 1'b0, 1, "R8 restart fresh period");
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule